// File: doc/BRIEF.md
# Free-Running Video Test Pattern Generator

This block creates a complete video timing and a one-bit test image with no incoming sync at all. It is meant for burn-in runs in the factory and for a quick picture check by the user. It counts dots on a dot-clock enable taken from the system clock. From that count it produces horizontal sync, vertical sync, a blanking flag and a video bit. A two-bit timing code picks one of three horizontal line rates, near 31.75 kHz, 47.6 kHz and 63.5 kHz. Each rate has its own lines-per-frame count, so the frame rate stays at a nominal 60 Hz. A two-bit pattern code picks positive cross-hatch, negative cross-hatch, solid white or solid black.

The generator drives a pin that it shares with a general-purpose port bit. While the enable is high the pin carries the video bit, and while it is low the pin carries the port bit. A new timing or pattern code is applied only at the start of the next frame, so a frame in progress is never cut short or stretched. Each mode has its own line length, active width, frame length and active height, all set by parameters. The front porch and sync widths are shared across the three modes.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is asserted and after it is released with `en` low, the outputs read `hsync`=0, `vsync`=0, `blank`=1 and `video`=0.
- R2: While `en` is low, the dot and line counters are held at zero, the outputs stay idle as in R1, and the current codes are taken in directly.
- R3: The `mode_sel` code 00 gives a line of H_TOT_M0 dots (about 31.75 kHz by default). Code 01 gives H_TOT_M1 dots (about 47.6 kHz) and code 10 gives H_TOT_M2 dots (about 63.5 kHz). Code 11 behaves exactly like 00.
- R4: Each mode has its own frame length of V_TOT_Mx lines, and the active height is V_ACT_Mx lines. The defaults give 60 Hz in every mode.
- R5: `hsync` is high for H_SW dots, starting H_FP dots after the last active dot of a line. `vsync` is high for V_SW lines, starting V_FP lines after the last active line.
- R6: `blank` is high whenever the dot index is at or above the mode's active width, or the line index is at or above its active height.
- R7: The `pat_sel` codes are: 00 positive cross-hatch, 01 negative cross-hatch (the inverse of 00), 10 solid white (`video`=1) and 11 solid black (`video`=0).
- R8: In positive cross-hatch, `video` is 1 on every dot whose index is a multiple of 2^GRID_LOG2, and on every line whose index is a multiple of 2^GRID_LOG2. It is 0 on all other dots. Indices count from 0 at the top-left active dot.
- R9: `video` is 0 whenever `blank` is high, in every pattern.
- R10: A change of `mode_sel` or `pat_sel` while `en` is high takes effect at the first dot of the next frame.
- R11: A dot is counted only in a cycle with `dot_en` high. In any other cycle all outputs hold.
- R12: `pin_out` equals `video` while `en` is high and equals `gpio_in` while `en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| dot_en | input | 1 | One-cycle dot strobe |
| mode_sel | input | 2 | Horizontal rate code |
| pat_sel | input | 2 | Pattern code |
| gpio_in | input | 1 | Port bit that shares the output pin |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking flag |
| video | output | 1 | One-bit picture |
| pin_out | output | 1 | Shared pin: video or port bit |

## Verification
The hardest case is a code change that arrives while a frame is running. It must stay invisible until the exact dot where the old frame wraps, and from that dot on the new mode's line and frame lengths apply. The stimulus switches both codes partway through a frame with the enable held high and runs across several wraps. A second run places irregular `dot_en` gaps across line and frame ends, so that stalls fall on the wrap dot itself. Small timing parameters let every mode finish several whole frames, so each dot is compared against a model built from the requirements.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    PAT_POS   = 2'b00,
    PAT_NEG   = 2'b01,
    PAT_WHITE = 2'b10,
    PAT_BLACK = 2'b11
  } pat_e;
endpackage

// File: rtl/tpg_timing.sv
module tpg_timing
  import tpg_pkg::*;
#(
  parameter int HW       = 10,
  parameter int VW       = 11,
  parameter int H_TOT_M0 = 800,
  parameter int H_ACT_M0 = 640,
  parameter int H_TOT_M1 = 534,
  parameter int H_ACT_M1 = 424,
  parameter int H_TOT_M2 = 400,
  parameter int H_ACT_M2 = 320,
  parameter int V_TOT_M0 = 525,
  parameter int V_ACT_M0 = 480,
  parameter int V_TOT_M1 = 794,
  parameter int V_ACT_M1 = 720,
  parameter int V_TOT_M2 = 1058,
  parameter int V_ACT_M2 = 960,
  parameter int H_FP     = 16,
  parameter int H_SW     = 61,
  parameter int V_FP     = 10,
  parameter int V_SW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dot_en,
  input  logic [1:0]    mode_in,
  input  pat_e          pat_in,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output pat_e          pat_cur,
  output logic          hsync,
  output logic          vsync,
  output logic          blank
);

  logic [HW-1:0] h_q, h_d, h_last, h_act, h_ss, h_se;
  logic [VW-1:0] v_q, v_d, v_last, v_act, v_ss, v_se;
  logic [1:0]    mode_q, mode_d;
  pat_e          pat_q, pat_d;
  logic          line_end, frame_end;

  // per-mode limits
  always_comb begin
    case (mode_q)
      2'b01: begin
        h_last = HW'(H_TOT_M1 - 1);
        h_act  = HW'(H_ACT_M1);
        h_ss   = HW'(H_ACT_M1 + H_FP);
        h_se   = HW'(H_ACT_M1 + H_FP + H_SW);
        v_last = VW'(V_TOT_M1 - 1);
        v_act  = VW'(V_ACT_M1);
        v_ss   = VW'(V_ACT_M1 + V_FP);
        v_se   = VW'(V_ACT_M1 + V_FP + V_SW);
      end
      2'b10: begin
        h_last = HW'(H_TOT_M2 - 1);
        h_act  = HW'(H_ACT_M2);
        h_ss   = HW'(H_ACT_M2 + H_FP);
        h_se   = HW'(H_ACT_M2 + H_FP + H_SW);
        v_last = VW'(V_TOT_M2 - 1);
        v_act  = VW'(V_ACT_M2);
        v_ss   = VW'(V_ACT_M2 + V_FP);
        v_se   = VW'(V_ACT_M2 + V_FP + V_SW);
      end
      default: begin
        h_last = HW'(H_TOT_M0 - 1);
        h_act  = HW'(H_ACT_M0);
        h_ss   = HW'(H_ACT_M0 + H_FP);
        h_se   = HW'(H_ACT_M0 + H_FP + H_SW);
        v_last = VW'(V_TOT_M0 - 1);
        v_act  = VW'(V_ACT_M0);
        v_ss   = VW'(V_ACT_M0 + V_FP);
        v_se   = VW'(V_ACT_M0 + V_FP + V_SW);
      end
    endcase
  end

  assign line_end  = (h_q == h_last);
  assign frame_end = line_end && (v_q == v_last);

  // next state
  always_comb begin
    h_d    = h_q;
    v_d    = v_q;
    mode_d = mode_q;
    pat_d  = pat_q;
    if (!en) begin
      h_d    = '0;
      v_d    = '0;
      mode_d = mode_in;
      pat_d  = pat_in;
    end else if (dot_en) begin
      if (line_end) begin
        h_d = '0;
        if (frame_end) begin
          v_d    = '0;
          mode_d = mode_in;
          pat_d  = pat_in;
        end else begin
          v_d = v_q + 1'b1;
        end
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      mode_q <= 2'b00;
      pat_q  <= PAT_POS;
    end else begin
      h_q    <= h_d;
      v_q    <= v_d;
      mode_q <= mode_d;
      pat_q  <= pat_d;
    end
  end

  assign h_cnt   = h_q;
  assign v_cnt   = v_q;
  assign pat_cur = pat_q;
  assign hsync   = en && (h_q >= h_ss) && (h_q < h_se);
  assign vsync   = en && (v_q >= v_ss) && (v_q < v_se);
  assign blank   = !en || (h_q >= h_act) || (v_q >= v_act);

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (h_q <= h_last)); // R3
  AST_V_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (v_q <= v_last)); // R4
  AST_DOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dot_en) |=> (!en || (h_q == $past(h_q) && v_q == $past(v_q)))); // R11
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(dot_en && frame_end)) |=> (!en || ($stable(mode_q) && $stable(pat_q)))); // R10

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
  import tpg_pkg::*;
#(
  parameter int GRID_LOG2 = 5
) (
  input  logic                 blank,
  input  logic [GRID_LOG2-1:0] h_low,
  input  logic [GRID_LOG2-1:0] v_low,
  input  pat_e                 pat,
  output logic                 video
);

  logic on_grid;
  logic pix;

  assign on_grid = (h_low == '0) || (v_low == '0);

  always_comb begin
    case (pat)
      PAT_POS:   pix = on_grid;
      PAT_NEG:   pix = !on_grid;
      PAT_WHITE: pix = 1'b1;
      default:   pix = 1'b0;
    endcase
  end

  assign video = pix && !blank;

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int H_TOT_M0  = 800,
  parameter int H_ACT_M0  = 640,
  parameter int H_TOT_M1  = 534,
  parameter int H_ACT_M1  = 424,
  parameter int H_TOT_M2  = 400,
  parameter int H_ACT_M2  = 320,
  parameter int V_TOT_M0  = 525,
  parameter int V_ACT_M0  = 480,
  parameter int V_TOT_M1  = 794,
  parameter int V_ACT_M1  = 720,
  parameter int V_TOT_M2  = 1058,
  parameter int V_ACT_M2  = 960,
  parameter int H_FP      = 16,
  parameter int H_SW      = 61,
  parameter int V_FP      = 10,
  parameter int V_SW      = 2,
  parameter int GRID_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       dot_en,
  input  logic [1:0] mode_sel,
  input  logic [1:0] pat_sel,
  input  logic       gpio_in,
  output logic       hsync,
  output logic       vsync,
  output logic       blank,
  output logic       video,
  output logic       pin_out
);

  localparam int H_MAX01 = (H_TOT_M0 > H_TOT_M1) ? H_TOT_M0 : H_TOT_M1;
  localparam int H_MAX   = (H_MAX01 > H_TOT_M2) ? H_MAX01 : H_TOT_M2;
  localparam int V_MAX01 = (V_TOT_M0 > V_TOT_M1) ? V_TOT_M0 : V_TOT_M1;
  localparam int V_MAX   = (V_MAX01 > V_TOT_M2) ? V_MAX01 : V_TOT_M2;
  localparam int HW      = $clog2(H_MAX);
  localparam int VW      = $clog2(V_MAX);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  pat_e          pat_cur;

  tpg_timing #(
    .HW(HW), .VW(VW),
    .H_TOT_M0(H_TOT_M0), .H_ACT_M0(H_ACT_M0),
    .H_TOT_M1(H_TOT_M1), .H_ACT_M1(H_ACT_M1),
    .H_TOT_M2(H_TOT_M2), .H_ACT_M2(H_ACT_M2),
    .V_TOT_M0(V_TOT_M0), .V_ACT_M0(V_ACT_M0),
    .V_TOT_M1(V_TOT_M1), .V_ACT_M1(V_ACT_M1),
    .V_TOT_M2(V_TOT_M2), .V_ACT_M2(V_ACT_M2),
    .H_FP(H_FP), .H_SW(H_SW), .V_FP(V_FP), .V_SW(V_SW)
  ) u_timing (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .dot_en  (dot_en),
    .mode_in (mode_sel),
    .pat_in  (pat_e'(pat_sel)),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .pat_cur (pat_cur),
    .hsync   (hsync),
    .vsync   (vsync),
    .blank   (blank)
  );

  tpg_pattern #(.GRID_LOG2(GRID_LOG2)) u_pattern (
    .blank (blank),
    .h_low (h_cnt[GRID_LOG2-1:0]),
    .v_low (v_cnt[GRID_LOG2-1:0]),
    .pat   (pat_cur),
    .video (video)
  );

  assign pin_out = en ? video : gpio_in;

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !video); // R9
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (blank && !hsync && !vsync && (pin_out == gpio_in))); // R2

endmodule

// File: tb/test_pattern_gen_test.sv
`timescale 1ns/1ps
module test_pattern_gen_test;

  localparam int HFP = 1, HSW = 3, VFP = 1, VSW = 2, GL = 2;
  int htot [3] = '{16, 14, 12};
  int hact [3] = '{8, 7, 6};
  int vtot [3] = '{10, 12, 14};
  int vact [3] = '{6, 8, 10};

  logic clk = 1'b0;
  logic rst_n, en, dot_en, gpio_in;
  logic [1:0] mode_sel, pat_sel;
  logic hsync, vsync, blank, video, pin_out;

  always #2 clk = ~clk;

  test_pattern_gen #(
    .H_TOT_M0(16), .H_ACT_M0(8), .H_TOT_M1(14), .H_ACT_M1(7),
    .H_TOT_M2(12), .H_ACT_M2(6), .V_TOT_M0(10), .V_ACT_M0(6),
    .V_TOT_M1(12), .V_ACT_M1(8), .V_TOT_M2(14), .V_ACT_M2(10),
    .H_FP(HFP), .H_SW(HSW), .V_FP(VFP), .V_SW(VSW), .GRID_LOG2(GL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dot_en(dot_en),
    .mode_sel(mode_sel), .pat_sel(pat_sel), .gpio_in(gpio_in),
    .hsync(hsync), .vsync(vsync), .blank(blank), .video(video),
    .pin_out(pin_out)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [4:0] exp_q [$];
  string      tag_q [$];

  // model state
  int m_h = 0, m_v = 0, m_mode = 0, m_pat = 0;

  function automatic int midx(int code);
    return (code == 3) ? 0 : code;
  endfunction

  function automatic logic [4:0] expect_out(bit e, bit g);
    int  i;
    bit  hs, vs, bl, vid, line;
    i = midx(m_mode);
    if (!e) return {1'b0, 1'b0, 1'b1, 1'b0, g};
    hs = (m_h >= hact[i] + HFP) && (m_h < hact[i] + HFP + HSW);
    vs = (m_v >= vact[i] + VFP) && (m_v < vact[i] + VFP + VSW);
    bl = (m_h >= hact[i]) || (m_v >= vact[i]);
    line = ((m_h % (1 << GL)) == 0) || ((m_v % (1 << GL)) == 0);
    case (m_pat)
      0: vid = line;
      1: vid = !line;
      2: vid = 1'b1;
      default: vid = 1'b0;
    endcase
    if (bl) vid = 1'b0;
    return {hs, vs, bl, vid, vid};
  endfunction

  task automatic step(bit e, bit d, int mode, int pat, bit g, string tag);
    int i;
    @(negedge clk);
    en = e; dot_en = d; mode_sel = mode[1:0]; pat_sel = pat[1:0]; gpio_in = g;
    exp_q.push_back(expect_out(e, g));
    tag_q.push_back(tag);
    // advance model for the coming edge
    i = midx(m_mode);
    if (!rst_n || !e) begin
      m_h = 0; m_v = 0;
      if (rst_n) begin m_mode = mode; m_pat = pat; end
      else begin m_mode = 0; m_pat = 0; end
    end else if (d) begin
      if (m_h == htot[i] - 1) begin
        m_h = 0;
        if (m_v == vtot[i] - 1) begin
          m_v = 0; m_mode = mode; m_pat = pat;
        end else m_v = m_v + 1;
      end else m_h = m_h + 1;
    end
  endtask

  task automatic cmp(string req, string what, logic a, logic x);
    total++;
    if (a !== x) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, a, x, $time);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    logic [4:0] ex;
    string      tg;
    #1;
    if (exp_q.size() > 0) begin
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      cmp("R5", "hsync", hsync, ex[4]);
      cmp("R5", "vsync", vsync, ex[3]);
      cmp("R6", "blank", blank, ex[2]);
      cmp(tg, "video", video, ex[1]);
      cmp("R12", "pin_out", pin_out, ex[0]);
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; dot_en = 1'b0; mode_sel = 2'b00;
    pat_sel = 2'b00; gpio_in = 1'b0;
    // R1: reset state
    for (int k = 0; k < 4; k++) step(0, 1, 2, 1, k[0], "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 1'b0, "R1");
    // R2: disabled, gpio passes through
    for (int k = 0; k < 20; k++) step(0, k[1], 1, 2, k[0] ^ k[2], "R2");
    // R8: mode 00 positive cross-hatch
    for (int k = 0; k < 2 * 160; k++) step(1, 1, 0, 0, 1'b1, "R8");
    // R4: mode 01 negative cross-hatch
    step(0, 1, 1, 1, 1'b0, "R4");
    for (int k = 0; k < 2 * 168; k++) step(1, 1, 1, 1, 1'b0, "R4");
    // R9: mode 10 solid white
    step(0, 1, 2, 2, 1'b0, "R9");
    for (int k = 0; k < 2 * 168; k++) step(1, 1, 2, 2, 1'b1, "R9");
    // R7: solid black
    step(0, 1, 2, 3, 1'b1, "R7");
    for (int k = 0; k < 168; k++) step(1, 1, 2, 3, 1'b1, "R7");
    // R3: code 11 behaves as code 00
    step(0, 1, 3, 0, 1'b0, "R3");
    for (int k = 0; k < 2 * 160; k++) step(1, 1, 3, 0, 1'b0, "R3");
    // R10: codes change mid-frame
    step(0, 1, 0, 0, 1'b0, "R10");
    for (int k = 0; k < 50; k++) step(1, 1, 0, 0, 1'b0, "R10");
    for (int k = 0; k < 400; k++) step(1, 1, 1, 1, 1'b0, "R10");
    for (int k = 0; k < 300; k++) step(1, 1, 2, 2, 1'b0, "R10");
    // R11: irregular dot strobe across wraps
    for (int k = 0; k < 700; k++) step(1, (k % 3) != 0 && (k % 7) != 5, 0, 1, 1'b0, "R11");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule